// File: doc/BRIEF.md
# Predicated Quadword Load-Replicate Unit

This unit runs one predicated, byte-granular load of a 128-bit quadword and spreads the result across a wide vector destination. A command carries a 32-bit instruction word, a 64-bit base value, a 64-bit index value and a predicate register value. The base value is the one the register file supplies for the base field, and that value is the stack pointer when the field reads 31. The unit decodes the word and forms the start address. It then fetches only the bytes whose predicate bit is set, over a single-outstanding byte memory port. The missing lanes are filled with zero. When the quadword is complete, the unit presents it replicated VL/128 times, together with the destination register number.

Commands arrive on a valid/ready channel. `cmd_ready` is high only while the unit is idle, so a command offered while a load is in progress waits. Memory requests also use valid/ready: once `mem_req_valid` is raised, it stays high with a stable address until `mem_req_ready` is seen. Responses have no back-pressure, and exactly one response must return for each accepted request. Results, the undefined-encoding flag and the alignment-check flag are single-cycle pulses.

Top module: `qrep_load_unit`

## Requirements
- R1: A word is legal only if bits 31..21 are 10100100000, bits 15..13 are 000 and bits 20..16 are not 11111. Any other accepted word raises `undef_flag` for exactly the cycle after acceptance, issues no memory request and produces no writeback.
- R2: A word whose field in bits 20..16 is 11111 is flagged undefined, and no memory access follows it.
- R3: For a legal word whose bits 9..5 equal 31, `sp_align_chk` pulses in the cycle after acceptance. It stays low for every other legal or illegal word.
- R4: The start address is base + index modulo 2^64. Lane e (0..15) reads the byte at start + e, also wrapping modulo 2^64.
- R5: Reads go out in ascending lane order with at most one outstanding. A request held against a low `mem_req_ready` keeps its valid and address unchanged. Each new request appears in the cycle after the previous response.
- R6: A lane whose predicate bit is 0 issues no read, and its byte is written as zero.
- R7: Only `cmd_pred[15:0]` govern the load. Predicate bits 16 and higher have no effect on the reads or on the result.
- R8: Lane e occupies bits 8e+7..8e of the quadword. Copy k of the quadword fills `wb_data` bits 128k+127..128k, and `wb_reg` carries bits 4..0 of the word.
- R9: `wb_valid` pulses for one cycle, in the cycle after the last response. With all sixteen low predicate bits clear, it pulses in the cycle after acceptance, with all-zero data and no reads.
- R10: `cmd_ready` is low from acceptance of a legal word until after its writeback pulse, and a command offered in that window is not taken.
- R11: For a fixed predicate and fixed memory timing, the number of cycles from acceptance to writeback does not depend on the loaded data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command taken on valid and ready |
| cmd_instr | input | 32 | Instruction word |
| cmd_base | input | 64 | Base value (stack pointer when bits 9..5 are 31) |
| cmd_index | input | 64 | Index value |
| cmd_pred | input | VL/8 | Predicate register value, low 16 bits used |
| mem_req_valid | output | 1 | Byte read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Byte address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 8 | Read byte |
| wb_valid | output | 1 | Destination result valid (one-cycle pulse) |
| wb_reg | output | 5 | Destination register number |
| wb_data | output | VL | Replicated quadword |
| undef_flag | output | 1 | Undefined-encoding pulse |
| sp_align_chk | output | 1 | Stack-pointer alignment check request pulse |

## Verification
The assertions assume that the memory returns a response only while a request is outstanding and not yet answered, and that it never answers the same request twice. In practice this means `mem_rsp_valid` is never high while the unit is asking or idle. The bench memory model keeps to this rule: it holds a single pending entry that is created on a request handshake and answered once, after a latency of one to three cycles. Back-pressure on requests and command offers made during a busy load are driven on purpose, because both are legal inputs.

// File: rtl/qrep_pkg.sv
package qrep_pkg;
  localparam int LANES  = 16;
  localparam int BYTE_W = 8;
  localparam int QW     = LANES * BYTE_W;
  localparam int ADDR_W = 64;
  localparam int LIDX_W = $clog2(LANES);

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DONE} ld_state_e;

  typedef struct packed {
    logic       legal;
    logic       sp_base;
    logic [4:0] zt;
  } ld_dec_t;
endpackage

// File: rtl/qrep_decode.sv
module qrep_decode
  import qrep_pkg::*;
(
  input  logic [31:0] instr,
  output ld_dec_t     dec
);
  localparam logic [10:0] OPC_HI  = 11'b10100100000;
  localparam logic [2:0]  OPC_MID = 3'b000;
  localparam logic [4:0]  REG_31  = 5'd31;

  logic [4:0] idx_reg;
  logic [4:0] base_reg;
  logic [2:0] unused_pg;

  always_comb begin
    idx_reg     = instr[20:16];
    base_reg    = instr[9:5];
    unused_pg   = instr[12:10];
    dec.legal   = (instr[31:21] == OPC_HI) && (instr[15:13] == OPC_MID)
                  && (idx_reg != REG_31);
    dec.sp_base = (base_reg == REG_31);
    dec.zt      = instr[4:0];
  end
endmodule

// File: rtl/qrep_lane_pick.sv
module qrep_lane_pick
  import qrep_pkg::*;
(
  input  logic [LANES-1:0]  mask,
  output logic [LIDX_W-1:0] lane,
  output logic              any
);
  always_comb begin
    lane = '0;
    any  = 1'b0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (mask[i]) begin
        lane = LIDX_W'(i);
        any  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/qrep_replicate.sv
module qrep_replicate
  import qrep_pkg::*;
#(
  parameter int VL = 256
) (
  input  logic [QW-1:0] quad,
  output logic [VL-1:0] wide
);
  localparam int COPIES = VL / QW;

  for (genvar k = 0; k < COPIES; k++) begin : g_copy
    assign wide[k*QW +: QW] = quad;
  end
endmodule

// File: rtl/qrep_load_unit.sv
module qrep_load_unit
  import qrep_pkg::*;
#(
  parameter int VL = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [31:0]       cmd_instr,
  input  logic [63:0]       cmd_base,
  input  logic [63:0]       cmd_index,
  input  logic [VL/8-1:0]   cmd_pred,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [63:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_data,
  output logic              wb_valid,
  output logic [4:0]        wb_reg,
  output logic [VL-1:0]     wb_data,
  output logic              undef_flag,
  output logic              sp_align_chk
);
  localparam int PL = VL / 8;

  ld_dec_t           dec;
  ld_state_e         state_q;
  logic [ADDR_W-1:0] start_q;
  logic [LANES-1:0]  remain_q;
  logic [LANES-1:0]  remain_nx;
  logic [QW-1:0]     quad_q;
  logic [4:0]        zt_q;
  logic              undef_q;
  logic              align_q;
  logic [LIDX_W-1:0] lane;
  logic              lane_any;
  logic [LANES-1:0]  pred_lo;
  logic              accept;

  assign pred_lo = cmd_pred[LANES-1:0];

  if (PL > LANES) begin : g_hi
    logic unused_pred_hi;
    assign unused_pred_hi = ^cmd_pred[PL-1:LANES];
  end

  qrep_decode u_dec (
    .instr (cmd_instr),
    .dec   (dec)
  );

  qrep_lane_pick u_pick (
    .mask (remain_q),
    .lane (lane),
    .any  (lane_any)
  );

  qrep_replicate #(.VL(VL)) u_rep (
    .quad (quad_q),
    .wide (wb_data)
  );

  assign cmd_ready     = (state_q == ST_IDLE);
  assign accept        = cmd_valid && cmd_ready;
  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_req_addr  = start_q + ADDR_W'(lane);
  assign wb_valid      = (state_q == ST_DONE);
  assign wb_reg        = zt_q;
  assign undef_flag    = undef_q;
  assign sp_align_chk  = align_q;

  always_comb begin
    remain_nx       = remain_q;
    remain_nx[lane] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      start_q  <= '0;
      remain_q <= '0;
      quad_q   <= '0;
      zt_q     <= '0;
      undef_q  <= 1'b0;
      align_q  <= 1'b0;
    end else begin
      undef_q <= 1'b0;
      align_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (!dec.legal) begin
              undef_q <= 1'b1;
            end else begin
              start_q  <= cmd_base + cmd_index;
              remain_q <= pred_lo;
              quad_q   <= '0;
              zt_q     <= dec.zt;
              align_q  <= dec.sp_base;
              state_q  <= (pred_lo == '0) ? ST_DONE : ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (mem_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            quad_q[{lane, 3'b000} +: BYTE_W] <= mem_rsp_data;
            remain_q <= remain_nx;
            state_q  <= (remain_nx == '0) ? ST_DONE : ST_REQ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R5
  AST_RSP_WHEN_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> (!mem_req_valid && !cmd_ready)); // R5
  AST_REQ_LANE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (lane_any && remain_q[lane])); // R6
  AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    undef_flag |-> (!mem_req_valid && !wb_valid && !sp_align_chk)); // R2
  AST_WB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid); // R9
  AST_EMPTY_MASK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec.legal && pred_lo == '0) |=> (wb_valid && wb_data == '0)); // R9
endmodule

// File: tb/sim_qrep_load_unit.sv
module sim_qrep_load_unit;
  localparam int VL = 512;
  localparam int PL = VL / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [31:0]   cmd_instr = '0;
  logic [63:0]   cmd_base = '0;
  logic [63:0]   cmd_index = '0;
  logic [PL-1:0] cmd_pred = '0;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic [63:0]   mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [7:0]    mem_rsp_data = '0;
  logic          wb_valid;
  logic [4:0]    wb_reg;
  logic [VL-1:0] wb_data;
  logic          undef_flag;
  logic          sp_align_chk;

  int   nvec = 0;
  int   nerr = 0;
  int   ncyc = 0;
  logic [7:0] salt = 8'h00;

  always #5 clk = ~clk;

  qrep_load_unit #(.VL(VL)) u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    ncyc++;
  endtask

  function automatic logic [7:0] mbyte(input logic [63:0] a);
    return a[7:0] ^ a[23:16] ^ salt ^ 8'h3C;
  endfunction

  function automatic logic [31:0] mk(input logic [4:0] rm, input logic [2:0] pg,
                                     input logic [4:0] rn, input logic [4:0] zt);
    return {11'b10100100000, rm, 3'b000, pg, rn, zt};
  endfunction

  task automatic run(input logic [31:0] ins, input logic [63:0] b, input logic [63:0] x,
                     input logic [PL-1:0] p, input bit fixed, input bit noise,
                     output int cycles);
    logic [63:0]  q[$];
    logic [127:0] expq;
    logic [VL-1:0] expw;
    logic [63:0]  cur;
    bit legal, sp, outst;
    int lat;
    legal = (ins[31:21] == 11'b10100100000) && (ins[15:13] == 3'b000) && (ins[20:16] != 5'd31);
    sp    = (ins[9:5] == 5'd31);
    expq  = '0;
    for (int e = 0; e < 16; e++) begin
      if (p[e]) begin
        q.push_back(b + x + 64'(e));
        expq[e*8 +: 8] = mbyte(b + x + 64'(e));
      end
    end
    for (int k = 0; k < VL / 128; k++) expw[k*128 +: 128] = expq;
    chk(cmd_ready, "R10", "ready when idle", 512'(cmd_ready), 512'd1);
    cmd_valid = 1'b1; cmd_instr = ins; cmd_base = b; cmd_index = x; cmd_pred = p;
    step();
    cmd_valid = noise;
    cmd_instr = mk(5'd2, 3'd0, 5'd31, 5'd9);
    cycles = 1;
    if (!legal) begin
      chk(undef_flag == 1'b1, "R1", "undef pulse", 512'(undef_flag), 512'd1);
      chk(!mem_req_valid && !wb_valid && !sp_align_chk, "R2", "quiet after undef",
          512'({mem_req_valid, wb_valid, sp_align_chk}), 512'd0);
      cmd_valid = 1'b0;
      step();
      chk(undef_flag == 1'b0 && cmd_ready, "R1", "undef one cycle",
          512'({undef_flag, cmd_ready}), 512'd1);
      return;
    end
    chk(undef_flag == 1'b0, "R1", "legal no undef", 512'(undef_flag), 512'd0);
    chk(sp_align_chk == sp, "R3", "align request", 512'(sp_align_chk), 512'(sp));
    outst = 1'b0; lat = 0; cur = '0;
    while (1) begin
      if (!outst && q.size() == 0) begin
        chk(wb_valid == 1'b1, "R9", "writeback timing", 512'(wb_valid), 512'd1);
        chk(wb_data == expw, "R8", "replicated data", 512'(wb_data), 512'(expw));
        chk(wb_reg == ins[4:0], "R8", "dest register", 512'(wb_reg), 512'(ins[4:0]));
        chk(!mem_req_valid, "R6", "no extra read", 512'(mem_req_valid), 512'd0);
        cmd_valid = 1'b0;
        step();
        chk(!wb_valid && cmd_ready, "R9", "single pulse",
            512'({wb_valid, cmd_ready}), 512'd1);
        break;
      end
      chk(!wb_valid, "R9", "no early writeback", 512'(wb_valid), 512'd0);
      chk(!cmd_ready, "R10", "busy not ready", 512'(cmd_ready), 512'd0);
      if (!outst) begin
        chk(mem_req_valid && mem_req_addr == q[0], "R4", "request address",
            512'({mem_req_valid, mem_req_addr}), 512'({1'b1, q[0]}));
        mem_req_ready = fixed ? 1'b1 : (($urandom % 3) != 0);
        if (mem_req_ready) begin
          cur = q.pop_front();
          outst = 1'b1;
          lat = fixed ? 2 : 1 + int'($urandom % 3);
        end
      end else begin
        chk(!mem_req_valid, "R5", "one outstanding", 512'(mem_req_valid), 512'd0);
        mem_req_ready = $urandom % 2;
        lat--;
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mbyte(cur);
          outst = 1'b0;
        end
      end
      step();
      mem_rsp_valid = 1'b0;
      mem_req_ready = 1'b0;
      cycles++;
    end
  endtask

  initial begin : watchdog
    while (ncyc < 100000) @(posedge clk);
    nvec++; nerr++;
    $display("FAIL watchdog: actual %0d expected below 100000", ncyc);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin : main
    int c0, c1;
    logic [PL-1:0] hi_only;
    hi_only = '0;
    hi_only[PL-1:16] = '1;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk(cmd_ready && !mem_req_valid && !wb_valid && !undef_flag && !sp_align_chk,
        "R10", "reset state",
        512'({cmd_ready, mem_req_valid, wb_valid, undef_flag, sp_align_chk}), 512'h10);
    // R4 R5 R8: all lanes active
    run(mk(5'd4, 3'd1, 5'd3, 5'd7), 64'h1000, 64'h20, PL'(16'hFFFF), 0, 0, c0);
    // R3 R6: alternating mask with stack-pointer base
    run(mk(5'd1, 3'd2, 5'd31, 5'd12), 64'h8000_0000, 64'h5, PL'(16'hA5A5), 0, 0, c0);
    // R6: only the top lane
    run(mk(5'd0, 3'd0, 5'd8, 5'd30), 64'h44, 64'h0, PL'(16'h8000), 0, 0, c0);
    // R9: empty mask, stack-pointer base still checked
    run(mk(5'd3, 3'd0, 5'd31, 5'd1), 64'h10, 64'h1, '0, 0, 0, c0);
    // R7: only high predicate bits set
    run(mk(5'd3, 3'd0, 5'd2, 5'd2), 64'h10, 64'h1, hi_only, 0, 0, c0);
    // R7: lane 0 plus high bits
    run(mk(5'd3, 3'd0, 5'd2, 5'd3), 64'h300, 64'h7, hi_only | PL'(1), 0, 0, c0);
    // R2: index field 31
    run(mk(5'd31, 3'd0, 5'd2, 5'd4), 64'h0, 64'h0, PL'(16'hFFFF), 0, 0, c0);
    // R1: bit 14 set, bits 15..13 not 000
    run(mk(5'd2, 3'd0, 5'd31, 5'd4) | 32'h4000, 64'h0, 64'h0, PL'(16'hFFFF), 0, 0, c0);
    // R1: bits 31..21 wrong
    run(mk(5'd2, 3'd0, 5'd2, 5'd4) ^ 32'h0020_0000, 64'h0, 64'h0, PL'(16'h1), 0, 0, c0);
    // R4: address wraps modulo 2^64
    run(mk(5'd5, 3'd0, 5'd6, 5'd5), 64'hFFFF_FFFF_FFFF_FFF8, 64'h4, PL'(16'hFFFF), 0, 0, c0);
    // R10: commands offered while busy are not taken
    run(mk(5'd5, 3'd0, 5'd6, 5'd6), 64'h2000, 64'h100, PL'(16'h0F0F), 0, 1, c0);
    // R11: same mask and timing, different data
    salt = 8'h00;
    run(mk(5'd5, 3'd0, 5'd6, 5'd8), 64'h4000, 64'h3, PL'(16'h6C39), 1, 0, c0);
    salt = 8'hA7;
    run(mk(5'd5, 3'd0, 5'd6, 5'd8), 64'h4000, 64'h3, PL'(16'h6C39), 1, 0, c1);
    chk(c0 == c1, "R11", "data-independent cycles", 512'(c1), 512'(c0));
    for (int i = 0; i < 20; i++) begin
      salt = 8'($urandom);
      run(mk(5'($urandom % 31), 3'd0, 5'($urandom), 5'($urandom)),
          {$urandom, $urandom}, {$urandom, $urandom}, PL'({$urandom, $urandom}), 0,
          i[0], c0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule